// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block screens the identifiers of received CAN frames before the host sees them. Each frame arrives as a one-cycle strobe with 32 identifier bits, ordered as four bytes, and a flag that marks it as an extended-format or standard-format frame. The identifier is always captured into a background slot. It is then compared bit by bit against four programmable code bytes. Wherever the matching mask bit is 1, that bit is treated as don't-care. An extended frame is tested on all four bytes and a standard frame only on the first two. A frame that passes is copied into a foreground slot and the host gets a one-cycle receive pulse. A frame that fails raises only a one-cycle drop pulse and stays in the background slot until the next frame overwrites it.

The code and mask bytes are loaded through a small byte-wide write port. Writes take effect only while the controller is in configuration mode, which means both the mode request input and the mode acknowledge input are 1. A combinational read port returns any register at any time. Frames that arrive during configuration mode are discarded.

A four-state machine sequences the receive side. ST_IDLE waits for a frame. ST_INIT is held while configuration mode is active. ST_HIT lasts one cycle after an accepted frame and drives the receive pulse. ST_DROP lasts one cycle after a rejected frame and drives the drop pulse. The next state is chosen in this priority order: any state goes to ST_INIT when configuration mode is active; otherwise a strobe leads to ST_HIT or ST_DROP depending on the filter result; otherwise the machine returns to ST_IDLE. A strobe arriving in ST_HIT or ST_DROP is evaluated in the same way, so frames can arrive back to back.

Top module: `canf_filter`

## Requirements
- R1: After reset, every code and mask byte reads 0x00, both frame slots and their format flags are 0, and `rx_irq` and `rx_drop` are low.
- R2: While `cfg_req` and `cfg_ack` are both 1, a `reg_wr` strobe stores `reg_wdata` into the register at `reg_addr`. Addresses 0 to 3 select code bytes 0 to 3 and addresses 4 to 7 select mask bytes 0 to 3. `reg_rdata` always returns the addressed register.
- R3: A `reg_wr` strobe while `cfg_req` or `cfg_ack` is 0 leaves every code and mask byte unchanged.
- R4: Outside configuration mode, every strobed frame, accepted or not, appears on `bg_id`/`bg_ext` in the cycle after the strobe.
- R5: Identifier byte k is `rx_id[31-8k -: 8]` and is compared with code byte k. A mask bit of 1 makes that bit don't-care, and every bit with mask 0 must equal its code bit.
- R6: When `rx_ext` is 1, all four identifier bytes take part in the test.
- R7: When `rx_ext` is 0, only bytes 0 and 1 (`rx_id[31:16]`) take part, and bytes 2 and 3 have no effect on the result.
- R8: An accepted frame gives a one-cycle `rx_irq` pulse in the cycle after the strobe, and in that same cycle `fg_id`/`fg_ext` hold the frame.
- R9: A rejected frame gives a one-cycle `rx_drop` pulse with no `rx_irq`, and leaves `fg_id`/`fg_ext` unchanged. The next frame overwrites it in the background slot.
- R10: A frame strobed while configuration mode is active raises neither pulse and leaves both slots unchanged.
- R11: Consecutive strobes on adjacent cycles are each decided and reported in the cycle after their own strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration mode request |
| cfg_ack | input | 1 | Configuration mode acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 code, 4-7 mask) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Addressed register contents |
| rx_valid | input | 1 | One-cycle frame strobe |
| rx_id | input | 32 | Identifier bytes 0..3, byte 0 in the top bits |
| rx_ext | input | 1 | Frame format flag, 1 = extended |
| bg_id | output | 32 | Background slot identifier |
| bg_ext | output | 1 | Background slot format flag |
| fg_id | output | 32 | Foreground (accepted) slot identifier |
| fg_ext | output | 1 | Foreground slot format flag |
| rx_irq | output | 1 | One-cycle accepted-frame pulse |
| rx_drop | output | 1 | One-cycle rejected-frame pulse |

## Verification
The assertions assume that `rx_valid` and `reg_wr` are low during reset. They also assume that the mode inputs, the frame inputs and the write inputs stay steady around each rising edge, so that a strobe belongs to exactly one cycle. The bench changes every input only on the falling edge and holds strobes low through reset. It moves the two mode bits independently, which covers each half-asserted combination. Frame identifiers are built from the bench's own copy of the code and mask bytes, with no flips, flips confined to masked bits, or arbitrary flips, so accepted and rejected frames both occur often.

// File: rtl/canf_pkg.sv
package canf_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned ID_BYTES  = 4;
    localparam int unsigned STD_BYTES = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_HIT  = 2'd2,
        ST_DROP = 2'd3
    } canf_state_e;
endpackage

// File: rtl/canf_regs.sv
module canf_regs
    import canf_pkg::*;
#(
    parameter int unsigned BW     = BYTE_W,
    parameter int unsigned NB     = ID_BYTES,
    parameter int unsigned ADDR_W = $clog2(2 * NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BW-1:0]     reg_wdata,
    output logic [BW-1:0]     reg_rdata,
    output logic [NB*BW-1:0]  code_flat,
    output logic [NB*BW-1:0]  mask_flat
);
    localparam int unsigned NREG = 2 * NB;

    logic [BW-1:0] regs_q [NREG];

    // Byte k sits in the top of the flat vector for k = 0.
    for (genvar k = 0; k < NB; k++) begin : g_byte
        localparam int unsigned CODE_A = k;
        localparam int unsigned MASK_A = k + NB;
        logic wr_code;
        logic wr_mask;

        assign wr_code = cfg_mode && reg_wr && (reg_addr == ADDR_W'(CODE_A));
        assign wr_mask = cfg_mode && reg_wr && (reg_addr == ADDR_W'(MASK_A));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[CODE_A] <= '0;
                regs_q[MASK_A] <= '0;
            end else begin
                if (wr_code) regs_q[CODE_A] <= reg_wdata;
                if (wr_mask) regs_q[MASK_A] <= reg_wdata;
            end
        end

        assign code_flat[(NB-1-k)*BW +: BW] = regs_q[CODE_A];
        assign mask_flat[(NB-1-k)*BW +: BW] = regs_q[MASK_A];
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (reg_addr == ADDR_W'(i)) reg_rdata = regs_q[i];
        end
    end

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cfg_mode) |=> ($stable(code_flat) && $stable(mask_flat))); // R3

    AST_WR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cfg_mode && (reg_addr == ADDR_W'(0))) |=>
            (code_flat[NB*BW-1 -: BW] == $past(reg_wdata))); // R2
endmodule

// File: rtl/canf_match.sv
module canf_match
    import canf_pkg::*;
#(
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned NB = ID_BYTES,
    parameter int unsigned NS = STD_BYTES
) (
    input  logic [NB*BW-1:0] id,
    input  logic             ext,
    input  logic [NB*BW-1:0] code_flat,
    input  logic [NB*BW-1:0] mask_flat,
    output logic             accept
);
    logic [NB-1:0] byte_ok;

    for (genvar k = 0; k < NB; k++) begin : g_cmp
        logic [BW-1:0] id_b;
        logic [BW-1:0] cd_b;
        logic [BW-1:0] mk_b;
        assign id_b = id[(NB-1-k)*BW +: BW];
        assign cd_b = code_flat[(NB-1-k)*BW +: BW];
        assign mk_b = mask_flat[(NB-1-k)*BW +: BW];
        // Each bit passes when it equals the code bit or is masked.
        assign byte_ok[k] = &((id_b ~^ cd_b) | mk_b);
    end

    assign accept = ext ? (&byte_ok) : (&byte_ok[NS-1:0]);
endmodule

// File: rtl/canf_ctrl.sv
module canf_ctrl
    import canf_pkg::*;
#(
    parameter int unsigned W = ID_BYTES * BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_mode,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_id,
    input  logic         rx_ext,
    input  logic         hit,
    output logic [W-1:0] bg_id,
    output logic         bg_ext,
    output logic [W-1:0] fg_id,
    output logic         fg_ext,
    output logic         rx_irq,
    output logic         rx_drop
);
    canf_state_e state_q;
    canf_state_e state_d;
    logic        take;

    assign take = rx_valid && !cfg_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_DROP: begin
                if (cfg_mode)      state_d = ST_INIT;
                else if (rx_valid) state_d = hit ? ST_HIT : ST_DROP;
                else               state_d = ST_IDLE;
            end
            ST_INIT: begin
                if (cfg_mode)      state_d = ST_INIT;
                else if (rx_valid) state_d = hit ? ST_HIT : ST_DROP;
                else               state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_id  <= '0;
            bg_ext <= 1'b0;
            fg_id  <= '0;
            fg_ext <= 1'b0;
        end else if (take) begin
            bg_id  <= rx_id;
            bg_ext <= rx_ext;
            if (hit) begin
                fg_id  <= rx_id;
                fg_ext <= rx_ext;
            end
        end
    end

    assign rx_irq  = (state_q == ST_HIT);
    assign rx_drop = (state_q == ST_DROP);

    AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_mode) |=> (!rx_irq && !rx_drop && $stable(bg_id))); // R10

    AST_BG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_mode) |=> (bg_id == $past(rx_id))); // R4

    AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_irq && !rx_drop)); // R11

    AST_PROMOTED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (fg_id == bg_id && fg_ext == bg_ext)); // R8

    AST_DROP_KEEPS_FG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> ($stable(fg_id) && $stable(fg_ext))); // R9
endmodule

// File: rtl/canf_filter.sv
module canf_filter
    import canf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_req,
    input  logic        cfg_ack,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        rx_valid,
    input  logic [31:0] rx_id,
    input  logic        rx_ext,
    output logic [31:0] bg_id,
    output logic        bg_ext,
    output logic [31:0] fg_id,
    output logic        fg_ext,
    output logic        rx_irq,
    output logic        rx_drop
);
    localparam int unsigned W = ID_BYTES * BYTE_W;

    logic         cfg_mode;
    logic [W-1:0] code_flat;
    logic [W-1:0] mask_flat;
    logic         hit;

    assign cfg_mode = cfg_req && cfg_ack;

    canf_regs #(.BW(BYTE_W), .NB(ID_BYTES), .ADDR_W(3)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .code_flat (code_flat),
        .mask_flat (mask_flat)
    );

    canf_match #(.BW(BYTE_W), .NB(ID_BYTES), .NS(STD_BYTES)) u_match (
        .id        (rx_id),
        .ext       (rx_ext),
        .code_flat (code_flat),
        .mask_flat (mask_flat),
        .accept    (hit)
    );

    canf_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_mode (cfg_mode),
        .rx_valid (rx_valid),
        .rx_id    (rx_id),
        .rx_ext   (rx_ext),
        .hit      (hit),
        .bg_id    (bg_id),
        .bg_ext   (bg_ext),
        .fg_id    (fg_id),
        .fg_ext   (fg_ext),
        .rx_irq   (rx_irq),
        .rx_drop  (rx_drop)
    );

    AST_STD_IGNORES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_mode && !rx_ext && (((rx_id ^ code_flat) & ~mask_flat) >> 16) == 0)
            |=> rx_irq); // R7
endmodule

// File: tb/canf_filter_tb.sv
module canf_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0, cfg_ack = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_id = '0;
    logic        rx_ext = 1'b0;
    logic [31:0] bg_id, fg_id;
    logic        bg_ext, fg_ext, rx_irq, rx_drop;

    int checks = 0;
    int fails  = 0;
    logic [7:0]  m_regs [8];
    logic [31:0] m_bg = '0, m_fg = '0;
    logic        m_bgx = 1'b0, m_fgx = 1'b0;

    always #10 clk = ~clk;

    canf_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_ack(cfg_ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ext(rx_ext), .bg_id(bg_id), .bg_ext(bg_ext), .fg_id(fg_id),
        .fg_ext(fg_ext), .rx_irq(rx_irq), .rx_drop(rx_drop)
    );

    function automatic logic [31:0] code_vec();
        return {m_regs[0], m_regs[1], m_regs[2], m_regs[3]};
    endfunction

    function automatic logic [31:0] mask_vec();
        return {m_regs[4], m_regs[5], m_regs[6], m_regs[7]};
    endfunction

    function automatic logic exp_accept(logic [31:0] id, logic ext);
        logic [31:0] miss;
        miss = (id ^ code_vec()) & ~mask_vec();
        return ext ? (miss == 0) : (miss[31:16] == 0);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #1;
            chk(req, 32'(reg_rdata), 32'(m_regs[a]));
        end
    endtask

    task automatic set_mode(logic rq, logic ak);
        cfg_req = rq;
        cfg_ack = ak;
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (cfg_req && cfg_ack) m_regs[a] = d;
    endtask

    // Strobe one frame and check the cycle after it.
    task automatic frame(logic [31:0] id, logic ext, string req);
        logic acc, live;
        live = !(cfg_req && cfg_ack);
        acc  = live && exp_accept(id, ext);
        rx_valid = 1'b1; rx_id = id; rx_ext = ext;
        @(negedge clk);
        rx_valid = 1'b0;
        if (live) begin m_bg = id; m_bgx = ext; end
        if (acc)  begin m_fg = id; m_fgx = ext; end
        chk({req, " irq"},  32'(rx_irq),  32'(acc));
        chk({req, " drop"}, 32'(rx_drop), 32'(live && !acc));
        chk({req, " bg"},   bg_id, m_bg);
        chk({req, " bgx"},  32'(bg_ext), 32'(m_bgx));
        chk({req, " fg"},   fg_id, m_fg);
        chk({req, " fgx"},  32'(fg_ext), 32'(m_fgx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_regs("R1 regs");
        chk("R1 bg", bg_id, 32'h0);
        chk("R1 fg", fg_id, 32'h0);
        chk("R1 irq", 32'(rx_irq | rx_drop), 32'h0);

        // R2: load code and mask in configuration mode
        set_mode(1'b1, 1'b1);
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h12); wr(3'd3, 8'h80);
        wr(3'd4, 8'h00); wr(3'd5, 8'h0F); wr(3'd6, 8'h00); wr(3'd7, 8'hFF);
        check_regs("R2 readback");

        // R10: frame during configuration mode is discarded
        frame(32'hA53C1280, 1'b1, "R10 init frame");

        // R3: writes with only one mode bit set are ignored
        set_mode(1'b1, 1'b0);
        wr(3'd0, 8'h11);
        set_mode(1'b0, 1'b1);
        wr(3'd5, 8'h22);
        check_regs("R3 locked");
        set_mode(1'b0, 1'b0);
        wr(3'd3, 8'h33);
        check_regs("R3 locked idle");

        // R6: extended exact match, then byte 2 mismatch
        frame(32'hA53C1280, 1'b1, "R6 ext exact");
        frame(32'hA53C1380, 1'b1, "R6 ext byte2 miss");
        // R5: masked bits (byte1 low nibble, byte3) are don't-care
        frame(32'hA5371277, 1'b1, "R5 masked flips");
        frame(32'hA57C1280, 1'b1, "R5 unmasked flip");
        // R7: standard frame ignores bytes 2 and 3
        frame(32'hA53CDEAD, 1'b0, "R7 std accept");
        frame(32'hA43C1280, 1'b0, "R7 std byte0 miss");
        // R9: rejected frame then overwritten by next
        frame(32'hFFFFFFFF, 1'b1, "R9 reject");
        frame(32'h00000000, 1'b0, "R9 overwrite");
        // R8/R11: back-to-back frames
        frame(32'hA53C1280, 1'b1, "R8 hit");
        frame(32'hA53CBEEF, 1'b0, "R11 adjacent hit");
        frame(32'h5A3C1280, 1'b1, "R11 adjacent drop");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned sel;
            logic [31:0] flip;
            sel = $urandom % 10;
            if (sel == 0) begin
                set_mode(1'($urandom), 1'($urandom));
            end else if (sel < 3) begin
                wr(3'($urandom), 8'($urandom));
                check_regs(cfg_req && cfg_ack ? "R2 rand write" : "R3 rand locked");
            end else begin
                case ($urandom % 3)
                    0:       flip = 32'h0;
                    1:       flip = $urandom & mask_vec();
                    default: flip = $urandom;
                endcase
                frame(code_vec() ^ flip, 1'($urandom),
                      cfg_req && cfg_ack ? "R10 rand" : "R5 rand");
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule